// File: doc/BRIEF.md
# Automatic Level Control Gain Controller

This block watches a signed 16-bit sample stream from an ADC and keeps a 7-bit input-gain code, in half-decibel steps, at a level that avoids clipping. When a sample's magnitude goes past a selectable detection threshold, a limiter lowers the code by a programmable number of steps. When a whole recovery period, counted in external tick pulses, passes with no sample in or above a warning window just under that threshold, a recovery step raises the code again. Recovery never takes the code above a programmable ceiling.

Gain changes can be applied at once, or held as a single pending change. A held change is released on the next sign change of the sample stream or, failing that, after one recovery period of ticks. A newer limiter request replaces a held recovery request. The step size of a held change is applied to the gain code in force when the change is released. The analog amplifier and the register interface sit outside this block.

Top module: `alc_gain_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, the gain code equals INIT_GAIN (default 0x30), and no change is pending.
- R2: A valid sample whose magnitude exceeds 16423 (threshold select 0) or 20675 (select 1) is a limiter event. It lowers the code by lim_step+1 steps, where lim_step is 2 bits and 00..11 give 1..4.
- R3: A limiter step that would take the code below 0 leaves the code at 0.
- R4: A valid sample whose magnitude lies in (13045, 16423] for select 0, or in (16423, 20675] for select 1, leaves the gain unchanged and restarts the recovery count.
- R5: After TICKS_PER_PERIOD tick pulses with no limiter or window sample since the last restart or recovery event, a recovery event raises the code by 1 step (rec_step 0) or 2 steps (rec_step 1).
- R6: Recovery never sets the code above ref_code. If the code is already at or above ref_code, recovery leaves it unchanged.
- R7: With zc_bypass at 1, a change appears on the gain output at the clock edge that ends the cycle of its triggering sample or tick.
- R8: With zc_bypass at 0, a pending change is applied at the edge that ends the cycle of a valid sample whose sign bit differs from that of the previous valid sample.
- R9: With zc_bypass at 0 and no zero crossing, a pending change is applied at the edge of the TICKS_PER_PERIOD-th tick after it was stored.
- R10: A limiter request replaces a pending recovery request. The step of a pending change is applied to the gain code in force when the change is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Signed two's-complement sample |
| period_tick | input | 1 | One pulse per recovery sub-interval |
| thr_sel | input | 1 | Threshold select: 0 for -6 dBFS, 1 for -4 dBFS |
| lim_step | input | 2 | Limiter step minus one |
| rec_step | input | 1 | Recovery step: 0 for 1 step, 1 for 2 steps |
| zc_bypass | input | 1 | 1 applies changes at once; 0 waits for a zero crossing or a timeout |
| ref_code | input | 7 | Recovery ceiling code |
| gain | output | 7 | Current gain code |

## Verification
The limiter is driven with positive and negative samples above the threshold under both threshold selects. Samples inside the warning window must leave the gain unchanged, which separates the two comparators. Recovery is run with both step sizes and with a ceiling set just above, at and below the current code, which exposes overshoot and missing saturation. A long run of loud samples shows whether the code clips at zero or wraps. In gated mode, same-sign samples, a sign change and a tick-only wait tell the crossing release apart from the timeout release. A loud sample that arrives while a recovery is pending checks that the limiter request replaces it.

// File: rtl/alc_pkg.sv
package alc_pkg;
    localparam int SMP_W  = 16;
    localparam int MAG_W  = SMP_W + 1;
    localparam int GAIN_W = 7;
    localparam int AMT_W  = 3;

    localparam logic [MAG_W-1:0] MAG_M4DB = MAG_W'(20675);
    localparam logic [MAG_W-1:0] MAG_M6DB = MAG_W'(16423);
    localparam logic [MAG_W-1:0] MAG_M8DB = MAG_W'(13045);

    typedef enum logic [1:0] {LVL_QUIET, LVL_WINDOW, LVL_LOUD} level_t;
    typedef enum logic [1:0] {REQ_NONE, REQ_REC, REQ_LIM} req_kind_t;

    typedef struct packed {
        req_kind_t        kind;
        logic [AMT_W-1:0] amount;
    } gain_req_t;

    function automatic logic [MAG_W-1:0] magnitude(input logic [SMP_W-1:0] s);
        logic signed [MAG_W-1:0] ext;
        ext = signed'({s[SMP_W-1], s});
        if (ext[MAG_W-1])
            return $unsigned(-ext);
        return $unsigned(ext);
    endfunction

    function automatic level_t classify(input logic [MAG_W-1:0] mag, input logic sel);
        logic [MAG_W-1:0] hi;
        logic [MAG_W-1:0] lo;
        hi = sel ? MAG_M4DB : MAG_M6DB;
        lo = sel ? MAG_M6DB : MAG_M8DB;
        if (mag > hi)
            return LVL_LOUD;
        if (mag > lo)
            return LVL_WINDOW;
        return LVL_QUIET;
    endfunction

    function automatic logic [GAIN_W-1:0] apply_req(input logic [GAIN_W-1:0] g,
                                                    input gain_req_t r,
                                                    input logic [GAIN_W-1:0] ceiling);
        logic [GAIN_W-1:0] amt;
        amt = GAIN_W'(r.amount);
        case (r.kind)
            REQ_LIM: return (g > amt) ? g - amt : '0;
            REQ_REC: begin
                if (g >= ceiling)
                    return g;
                return ((ceiling - g) > amt) ? g + amt : ceiling;
            end
            default: return g;
        endcase
    endfunction
endpackage

// File: rtl/alc_peak_class.sv
module alc_peak_class
    import alc_pkg::*;
(
    input  logic [SMP_W-1:0] sample,
    input  logic             thr_sel,
    output level_t           level,
    output logic             sign
);
    logic [MAG_W-1:0] mag;

    always_comb begin
        mag   = magnitude(sample);
        level = classify(mag, thr_sel);
        sign  = sample[SMP_W-1];
    end
endmodule

// File: rtl/alc_recovery_timer.sv
module alc_recovery_timer #(
    parameter int PERIOD = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic restart,
    output logic rec_fire
);
    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt;

    assign rec_fire = tick && !restart && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (restart)
            cnt <= '0;
        else if (tick)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    // R4
    restart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> !rec_fire || (PERIOD == 1));
endmodule

// File: rtl/alc_change_gate.sv
module alc_change_gate
    import alc_pkg::*;
#(
    parameter int PERIOD = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      bypass,
    input  gain_req_t req,
    input  logic      zc,
    input  logic      tick,
    output logic      fire,
    output gain_req_t fire_req
);
    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    gain_req_t        pend;
    logic [CNT_W-1:0] tcnt;
    logic             has_pend;
    logic             tmo_hit;
    logic             pend_fire;
    logic             take;
    logic             immediate;

    always_comb begin
        has_pend  = (pend.kind != REQ_NONE);
        tmo_hit   = has_pend && tick && (tcnt == LAST);
        pend_fire = !bypass && has_pend && (zc || tmo_hit);
        immediate = bypass && (req.kind != REQ_NONE);
        take      = !bypass && (req.kind != REQ_NONE) &&
                    (!has_pend || pend_fire || req.kind == REQ_LIM || pend.kind == REQ_REC);
        fire      = immediate || pend_fire;
        fire_req  = immediate ? req : pend;
    end

    always_ff @(posedge clk) begin
        if (rst || bypass) begin
            pend <= '{kind: REQ_NONE, amount: '0};
            tcnt <= '0;
        end else if (take) begin
            pend <= req;
            tcnt <= '0;
        end else if (pend_fire) begin
            pend <= '{kind: REQ_NONE, amount: '0};
            tcnt <= '0;
        end else if (has_pend && tick) begin
            tcnt <= tcnt + 1'b1;
        end
    end

    // R8
    release_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_fire && !take) |=> pend.kind == REQ_NONE);

    // R10
    lim_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (!bypass && has_pend && pend.kind == REQ_LIM && !pend_fire) |=> pend.kind == REQ_LIM);
endmodule

// File: rtl/alc_gain_ctrl.sv
module alc_gain_ctrl
    import alc_pkg::*;
#(
    parameter int              TICKS_PER_PERIOD = 16,
    parameter logic [6:0]      INIT_GAIN        = 7'h30
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        smp_valid,
    input  logic [15:0] smp_data,
    input  logic        period_tick,
    input  logic        thr_sel,
    input  logic [1:0]  lim_step,
    input  logic        rec_step,
    input  logic        zc_bypass,
    input  logic [6:0]  ref_code,
    output logic [6:0]  gain
);
    level_t            level;
    logic              smp_sign;
    logic              prev_sign;
    logic              have_prev;
    logic              zc;
    logic              restart;
    logic              rec_fire;
    logic              gate_fire;
    gain_req_t         new_req;
    gain_req_t         fire_req;
    logic [GAIN_W-1:0] gain_q;

    alc_peak_class u_class (
        .sample  (smp_data),
        .thr_sel (thr_sel),
        .level   (level),
        .sign    (smp_sign)
    );

    assign restart = smp_valid && (level != LVL_QUIET);
    assign zc      = smp_valid && have_prev && (smp_sign != prev_sign);

    alc_recovery_timer #(.PERIOD(TICKS_PER_PERIOD)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (period_tick),
        .restart  (restart),
        .rec_fire (rec_fire)
    );

    always_comb begin
        if (smp_valid && level == LVL_LOUD)
            new_req = '{kind: REQ_LIM, amount: AMT_W'(lim_step) + 1'b1};
        else if (rec_fire)
            new_req = '{kind: REQ_REC, amount: rec_step ? AMT_W'(2) : AMT_W'(1)};
        else
            new_req = '{kind: REQ_NONE, amount: '0};
    end

    alc_change_gate #(.PERIOD(TICKS_PER_PERIOD)) u_gate (
        .clk      (clk),
        .rst      (rst),
        .bypass   (zc_bypass),
        .req      (new_req),
        .zc       (zc),
        .tick     (period_tick),
        .fire     (gate_fire),
        .fire_req (fire_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gain_q    <= INIT_GAIN;
            prev_sign <= 1'b0;
            have_prev <= 1'b0;
        end else begin
            if (smp_valid) begin
                prev_sign <= smp_sign;
                have_prev <= 1'b1;
            end
            if (gate_fire)
                gain_q <= apply_req(gain_q, fire_req, ref_code);
        end
    end

    assign gain = gain_q;

    // R6
    rise_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
        (gain_q > $past(gain_q)) |-> gain_q <= $past(ref_code));

    // R5
    rise_size_chk: assert property (@(posedge clk) disable iff (rst)
        (gain_q > $past(gain_q)) |-> (gain_q - $past(gain_q)) <= GAIN_W'(2));

    // R2
    fall_size_chk: assert property (@(posedge clk) disable iff (rst)
        (gain_q < $past(gain_q)) |-> ($past(gain_q) - gain_q) <= GAIN_W'(4));

    // R9
    gated_update_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(zc_bypass) && gain_q != $past(gain_q)) |-> $past(gate_fire));
endmodule

// File: tb/sim_alc_gain_ctrl.sv
`timescale 1ns/1ps
module sim_alc_gain_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        period_tick = 1'b0;
    logic        thr_sel = 1'b0;
    logic [1:0]  lim_step = 2'd3;
    logic        rec_step = 1'b0;
    logic        zc_bypass = 1'b1;
    logic [6:0]  ref_code = 7'h34;
    logic [6:0]  gain;

    int checks = 0;
    int errors = 0;
    int mg;
    bit done = 0;
    int    exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    alc_gain_ctrl #(.TICKS_PER_PERIOD(4), .INIT_GAIN(7'h30)) u0 (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .period_tick(period_tick), .thr_sel(thr_sel), .lim_step(lim_step),
        .rec_step(rec_step), .zc_bypass(zc_bypass), .ref_code(ref_code), .gain(gain)
    );

    function automatic int m_lim(int g, int steps);
        return (g > steps) ? g - steps : 0;
    endfunction

    function automatic int m_rec(int g, int steps, int ceil_c);
        if (g >= ceil_c) return g;
        return (g + steps > ceil_c) ? ceil_c : g + steps;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (int'(gain) != e) begin
                errors++;
                $display("FAIL %s: gain actual %0h expected %0h", t, gain, e);
            end
        end
    end

    task automatic expect_gain(input string tag);
        exp_q.push_back(mg);
        tag_q.push_back(tag);
    endtask

    task automatic send(input logic [15:0] s);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = s;
        @(posedge clk);
        #1;
        smp_valid = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        period_tick = 1'b1;
        @(posedge clk);
        #1;
        period_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic finish_run();
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        mg = 'h30;
        repeat (3) @(negedge clk);
        expect_gain("R1 during reset");
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        expect_gain("R1 after reset");

        // R2 / R7: loud positive sample, select 0, 4 steps, immediate
        send(16'sd20000); mg = m_lim(mg, 4); expect_gain("R2 R7 loud sel0");
        // R4: same level is only in window for select 1
        thr_sel = 1'b1;
        send(16'sd20000); expect_gain("R4 window sel1 no change");
        send(16'sd21000); mg = m_lim(mg, 4); expect_gain("R2 loud sel1");
        lim_step = 2'd0;
        send(-16'sd21000); mg = m_lim(mg, 1); expect_gain("R2 negative 1 step");

        // R5: recovery by one step after a full period
        send(16'sd100);
        ticks(3); expect_gain("R5 before period end");
        tick(); mg = m_rec(mg, 1, 'h34); expect_gain("R5 step 1");

        // R4: window sample restarts the count
        ticks(2);
        send(16'sd18000); expect_gain("R4 window no change");
        ticks(3); expect_gain("R4 count restarted");
        tick(); mg = m_rec(mg, 1, 'h34); expect_gain("R4 R5 after restart");

        // R5 / R6: two-step recovery and ceiling
        rec_step = 1'b1;
        ticks(4); mg = m_rec(mg, 2, 'h34); expect_gain("R5 step 2");
        ref_code = 7'h2C;
        ticks(4); mg = m_rec(mg, 2, 'h2C); expect_gain("R6 saturate at ref");
        ticks(4); mg = m_rec(mg, 2, 'h2C); expect_gain("R6 hold at ref");

        // R3: clip at zero
        lim_step = 2'd3;
        for (int i = 0; i < 12; i++) begin
            send(16'sd30000); mg = m_lim(mg, 4);
        end
        expect_gain("R3 clip at zero");

        // R8: gated release at a sign change
        zc_bypass = 1'b0; ref_code = 7'h34; rec_step = 1'b0; lim_step = 2'd0;
        send(16'sd100);
        ticks(4); expect_gain("R8 pending held");
        send(16'sd200); expect_gain("R8 same sign no release");
        send(-16'sd100); mg = m_rec(mg, 1, 'h34); expect_gain("R8 release at crossing");

        // R9: timeout release
        ticks(4); expect_gain("R9 pending stored");
        ticks(3); expect_gain("R9 before timeout");
        tick(); mg = m_rec(mg, 1, 'h34); expect_gain("R9 timeout release");

        // R10: limiter replaces pending recovery, applied to current gain
        send(-16'sd30000); expect_gain("R10 limiter held");
        send(16'sd50); mg = m_lim(mg, 1); expect_gain("R10 limiter replaced recovery");

        // R6: code above ceiling is not raised
        zc_bypass = 1'b1; ref_code = 7'h00; rec_step = 1'b1;
        ticks(4); expect_gain("R6 above ref unchanged");

        finish_run();
    end
endmodule